// File: doc/BRIEF.md
# MD5 Block Compression Engine

This block performs the MD5 compression function on one 512-bit message block at a time. After a block is accepted it runs 64 steps, one per clock. Each step combines one working register with a bitwise round function, a message word, a sine-derived step constant and a left rotation. After the last step it adds the four working registers into the four chaining registers. The chaining registers carry over from block to block, so a long message is hashed by feeding its already padded blocks in order. The chaining value, byte-reordered, is the digest.

A message starts with `init`, which reloads the chaining registers with the standard initial value. `init` may be raised on the same cycle as the first block. Each block is offered with `blk_valid` and taken when `blk_ready` is high. The final block of a message is flagged with `blk_last`. When that block's compression finishes, `done` pulses for one cycle and `digest` holds the message hash.

The controller has three states, each with named transitions:

- IDLE: `blk_ready` is high.
  - ACCEPT (IDLE to RUN) happens when `blk_valid` is high.
- RUN: one compression step per cycle.
  - LAST_STEP (RUN to FOLD) happens after step 63.
- FOLD: the working registers are added into the chaining registers, and `done` is raised if the block was flagged last.
  - RETIRE (FOLD to IDLE) is unconditional.

Message padding and byte-stream assembly happen outside the block.

Top module: `md5_core`

## Requirements
- R1: After reset, `blk_ready`=1, `done`=0 and `digest`=128'h0123456789abcdeffedcba9876543210. This is the initial chaining value A=67452301, B=EFCDAB89, C=98BADCFE, D=10325476 in output byte order.
- R2: `init` while IDLE with `blk_valid` low reloads the chaining value, so `digest` shows the R1 value from the next cycle on.
- R3: A block is accepted on a clock edge where `blk_valid` and `blk_ready` are both 1. `blk_ready` is 0 for the next 65 cycles and is 1 again 66 cycles after the accepting edge.
- R4: `done` is a single-cycle pulse that rises 66 cycles after the accepting edge, only for a block accepted with `blk_last`=1. No pulse follows a block accepted with `blk_last`=0.
- R5: The compression uses the following, with all sums modulo 2^32:
  - Step constant: T_j = floor(2^32·|sin(j+1)|) for step j.
  - Round functions: F=(x&y)|(~x&z), G=(x&z)|(y&~z), H=x^y^z and I=y^(x|~z), one per 16-step round.
  - Rotations: 7,12,17,22 / 5,9,14,20 / 4,11,16,23 / 6,10,15,21, cycling within each round.
  - Message word index for step i of a round: i, (5i+1)%16, (3i+5)%16 and 7i%16.
  - Step update: new B = B + rotl(A + f(B,C,D) + X + T, s), then (A,B,C,D) takes the values (D, new B, B, C).
  - Finish: each working register is added to its chaining register.
- R6: Message word k is `blk_data[32k+31:32k]`, so message byte n sits at bits [8n+7:8n]. `digest[127:120]` is byte 0 of the hash, the low byte of A, followed by A's remaining bytes and then B, C and D in the same way. The one-block empty message yields d41d8cd98f00b204e9800998ecf8427e.
- R7: A block accepted without `init` starts from the chaining value left by the previous block.
- R8: `init` and `blk_valid` high together in IDLE compress the block from the initial chaining value, not from the previous result.
- R9: `init` raised while a block is being compressed has no effect on the result.
- R10: `blk_valid` and `blk_data` changes while busy are ignored. The block captured at acceptance is the one compressed.
- R11: `digest` changes only on the retiring edge of a compression or after an `init` in IDLE.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| init | input | 1 | Start a new message (reload initial chaining value) |
| blk_valid | input | 1 | A block is offered on `blk_data` |
| blk_ready | output | 1 | Engine is idle and can take a block |
| blk_data | input | 512 | Message block, word k at bits [32k+31:32k] |
| blk_last | input | 1 | Offered block is the final one of its message |
| digest | output | 128 | Chaining value in hash byte order |
| done | output | 1 | One-cycle pulse when a final block has been folded in |

## Verification
Two events can land on the same edge: a block acceptance and a chaining reload by `init`. The bench first leaves a non-initial chaining value behind, then raises `init` together with `blk_valid`. The resulting digest must equal a fresh compression from the initial value (R8), not a continuation of the previous value. The opposite overlap, `init` and a new `blk_valid`/`blk_data` arriving in the middle of a compression, is driven for one cycle. The digest must match the bench model of the originally captured block, and the block must take exactly the 66-cycle timing of R3 and R4.

// File: rtl/md5_pkg.sv
package md5_pkg;
    localparam int WORD_W    = 32;
    localparam int BLK_WORDS = 16;
    localparam int STEPS     = 64;
    localparam int BLK_W     = WORD_W * BLK_WORDS;
    localparam int DIG_W     = 4 * WORD_W;
    localparam int STEP_W    = $clog2(STEPS);
    localparam int IDX_W     = $clog2(BLK_WORDS);
    localparam int SH_W      = $clog2(WORD_W);

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        word_t a;
        word_t b;
        word_t c;
        word_t d;
    } quad_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FOLD = 2'd2
    } state_t;

    localparam quad_t CHAIN_IV = '{
        a: 32'h67452301,
        b: 32'hefcdab89,
        c: 32'h98badcfe,
        d: 32'h10325476
    };

    function automatic word_t rotl(input word_t x, input logic [SH_W-1:0] s);
        logic [2*WORD_W-1:0] wide;
        wide = {x, x} << s;
        return wide[2*WORD_W-1:WORD_W];
    endfunction

    // Message word used by a given step.
    function automatic logic [IDX_W-1:0] msg_index(input logic [STEP_W-1:0] step);
        logic [IDX_W-1:0] i;
        i = step[IDX_W-1:0];
        unique case (step[STEP_W-1:STEP_W-2])
            2'd0:    return i;
            2'd1:    return IDX_W'(5 * i + 1);
            2'd2:    return IDX_W'(3 * i + 5);
            default: return IDX_W'(7 * i);
        endcase
    endfunction

    // Rotation amount: four values per round, repeated four times.
    function automatic logic [SH_W-1:0] shift_amt(input logic [STEP_W-1:0] step);
        logic [3:0] sel;
        sel = {step[STEP_W-1:STEP_W-2], step[1:0]};
        unique case (sel)
            4'h0: return 5'd7;   4'h1: return 5'd12; 4'h2: return 5'd17; 4'h3: return 5'd22;
            4'h4: return 5'd5;   4'h5: return 5'd9;  4'h6: return 5'd14; 4'h7: return 5'd20;
            4'h8: return 5'd4;   4'h9: return 5'd11; 4'hA: return 5'd16; 4'hB: return 5'd23;
            4'hC: return 5'd6;   4'hD: return 5'd10; 4'hE: return 5'd15; default: return 5'd21;
        endcase
    endfunction

    function automatic word_t byte_rev(input word_t w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction
endpackage

// File: rtl/md5_const_rom.sv
module md5_const_rom
    import md5_pkg::*;
(
    input  logic [STEP_W-1:0] step,
    output word_t             tconst
);
    always_comb begin
        case (step)
            6'd0:  tconst = 32'hd76aa478;  6'd1:  tconst = 32'he8c7b756;
            6'd2:  tconst = 32'h242070db;  6'd3:  tconst = 32'hc1bdceee;
            6'd4:  tconst = 32'hf57c0faf;  6'd5:  tconst = 32'h4787c62a;
            6'd6:  tconst = 32'ha8304613;  6'd7:  tconst = 32'hfd469501;
            6'd8:  tconst = 32'h698098d8;  6'd9:  tconst = 32'h8b44f7af;
            6'd10: tconst = 32'hffff5bb1;  6'd11: tconst = 32'h895cd7be;
            6'd12: tconst = 32'h6b901122;  6'd13: tconst = 32'hfd987193;
            6'd14: tconst = 32'ha679438e;  6'd15: tconst = 32'h49b40821;
            6'd16: tconst = 32'hf61e2562;  6'd17: tconst = 32'hc040b340;
            6'd18: tconst = 32'h265e5a51;  6'd19: tconst = 32'he9b6c7aa;
            6'd20: tconst = 32'hd62f105d;  6'd21: tconst = 32'h02441453;
            6'd22: tconst = 32'hd8a1e681;  6'd23: tconst = 32'he7d3fbc8;
            6'd24: tconst = 32'h21e1cde6;  6'd25: tconst = 32'hc33707d6;
            6'd26: tconst = 32'hf4d50d87;  6'd27: tconst = 32'h455a14ed;
            6'd28: tconst = 32'ha9e3e905;  6'd29: tconst = 32'hfcefa3f8;
            6'd30: tconst = 32'h676f02d9;  6'd31: tconst = 32'h8d2a4c8a;
            6'd32: tconst = 32'hfffa3942;  6'd33: tconst = 32'h8771f681;
            6'd34: tconst = 32'h6d9d6122;  6'd35: tconst = 32'hfde5380c;
            6'd36: tconst = 32'ha4beea44;  6'd37: tconst = 32'h4bdecfa9;
            6'd38: tconst = 32'hf6bb4b60;  6'd39: tconst = 32'hbebfbc70;
            6'd40: tconst = 32'h289b7ec6;  6'd41: tconst = 32'heaa127fa;
            6'd42: tconst = 32'hd4ef3085;  6'd43: tconst = 32'h04881d05;
            6'd44: tconst = 32'hd9d4d039;  6'd45: tconst = 32'he6db99e5;
            6'd46: tconst = 32'h1fa27cf8;  6'd47: tconst = 32'hc4ac5665;
            6'd48: tconst = 32'hf4292244;  6'd49: tconst = 32'h432aff97;
            6'd50: tconst = 32'hab9423a7;  6'd51: tconst = 32'hfc93a039;
            6'd52: tconst = 32'h655b59c3;  6'd53: tconst = 32'h8f0ccc92;
            6'd54: tconst = 32'hffeff47d;  6'd55: tconst = 32'h85845dd1;
            6'd56: tconst = 32'h6fa87e4f;  6'd57: tconst = 32'hfe2ce6e0;
            6'd58: tconst = 32'ha3014314;  6'd59: tconst = 32'h4e0811a1;
            6'd60: tconst = 32'hf7537e82;  6'd61: tconst = 32'hbd3af235;
            6'd62: tconst = 32'h2ad7d2bb;  6'd63: tconst = 32'heb86d391;
            default: tconst = '0;
        endcase
    end
endmodule

// File: rtl/md5_step.sv
module md5_step
    import md5_pkg::*;
#(
    parameter bit F_AS_FOLD = 1'b1
) (
    input  quad_t           cur,
    input  word_t           msg,
    input  word_t           tconst,
    input  logic [SH_W-1:0] shamt,
    input  logic [1:0]      rnd,
    output word_t           new_b
);
    word_t f_val;
    word_t g_val;
    word_t h_val;
    word_t i_val;
    word_t mix;
    word_t sum;

    generate
        if (F_AS_FOLD) begin : g_f_fold
            // Two XORs and one AND, chained
            assign f_val = cur.d ^ (cur.b & (cur.c ^ cur.d));
        end else begin : g_f_mux
            assign f_val = (cur.b & cur.c) | (~cur.b & cur.d);
        end
    endgenerate

    assign g_val = (cur.b & cur.d) | (cur.c & ~cur.d);
    assign h_val = cur.b ^ cur.c ^ cur.d;
    assign i_val = cur.c ^ (cur.b | ~cur.d);

    always_comb begin
        unique case (rnd)
            2'd0:    mix = f_val;
            2'd1:    mix = g_val;
            2'd2:    mix = h_val;
            default: mix = i_val;
        endcase
    end

    assign sum   = cur.a + mix + msg + tconst;
    assign new_b = cur.b + rotl(sum, shamt);
endmodule

// File: rtl/md5_ctrl.sv
module md5_ctrl
    import md5_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              blk_valid,
    output logic              idle,
    output logic              load,
    output logic              step_en,
    output logic              fold,
    output logic [STEP_W-1:0] step
);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(STEPS - 1);

    state_t state;
    state_t state_nx;

    // Next-state: ACCEPT, LAST_STEP, RETIRE
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (blk_valid)         state_nx = ST_RUN;
            ST_RUN:  if (step == LAST_STEP) state_nx = ST_FOLD;
            ST_FOLD:                        state_nx = ST_IDLE;
            default:                        state_nx = ST_IDLE;
        endcase
    end

    // State register and step counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            step  <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE)
                step <= '0;
            else if (state == ST_RUN)
                step <= step + 1'b1;
        end
    end

    // Outputs
    always_comb begin
        idle    = 1'b0;
        load    = 1'b0;
        step_en = 1'b0;
        fold    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                idle = 1'b1;
                load = blk_valid;
            end
            ST_RUN:  step_en = 1'b1;
            ST_FOLD: fold    = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/md5_core.sv
module md5_core
    import md5_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init,
    input  logic             blk_valid,
    output logic             blk_ready,
    input  logic [BLK_W-1:0] blk_data,
    input  logic             blk_last,
    output logic [DIG_W-1:0] digest,
    output logic             done
);
    quad_t             chain_q;
    quad_t             work_q;
    logic [BLK_W-1:0]  blk_q;
    logic              last_q;
    logic              done_q;

    logic              idle;
    logic              load;
    logic              step_en;
    logic              fold;
    logic [STEP_W-1:0] step;

    word_t             words [BLK_WORDS];
    word_t             msg;
    word_t             tconst;
    word_t             new_b;

    md5_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .blk_valid (blk_valid),
        .idle      (idle),
        .load      (load),
        .step_en   (step_en),
        .fold      (fold),
        .step      (step)
    );

    genvar k;
    generate
        for (k = 0; k < BLK_WORDS; k++) begin : g_word
            assign words[k] = blk_q[k*WORD_W +: WORD_W];
        end
    endgenerate

    assign msg = words[msg_index(step)];

    md5_const_rom u_rom (
        .step   (step),
        .tconst (tconst)
    );

    md5_step #(.F_AS_FOLD(1'b1)) u_step (
        .cur    (work_q),
        .msg    (msg),
        .tconst (tconst),
        .shamt  (shift_amt(step)),
        .rnd    (step[STEP_W-1:STEP_W-2]),
        .new_b  (new_b)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= CHAIN_IV;
            work_q  <= '0;
            blk_q   <= '0;
            last_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (idle && init)
                chain_q <= CHAIN_IV;
            if (load) begin
                blk_q  <= blk_data;
                last_q <= blk_last;
                work_q <= init ? CHAIN_IV : chain_q;
            end
            if (step_en)
                work_q <= '{a: work_q.d, b: new_b, c: work_q.b, d: work_q.c};
            if (fold) begin
                chain_q.a <= chain_q.a + work_q.a;
                chain_q.b <= chain_q.b + work_q.b;
                chain_q.c <= chain_q.c + work_q.c;
                chain_q.d <= chain_q.d + work_q.d;
                done_q    <= last_q;
            end
        end
    end

    assign blk_ready = idle;
    assign done      = done_q;
    assign digest    = {byte_rev(chain_q.a), byte_rev(chain_q.b),
                        byte_rev(chain_q.c), byte_rev(chain_q.d)};
endmodule

// File: rtl/md5_core_chk.sv
module md5_core_chk
    import md5_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             init,
    input logic             blk_valid,
    input logic             blk_ready,
    input logic             blk_last,
    input logic [DIG_W-1:0] digest,
    input logic             done
);
    localparam int LAT = STEPS + 2;

    logic [7:0] since_acc;
    logic       last_seen;
    wire        accept = blk_valid && blk_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_acc <= '0;
            last_seen <= 1'b0;
        end else begin
            if (accept) begin
                since_acc <= 8'd1;
                last_seen <= blk_last;
            end else if (since_acc == 8'(LAT))
                since_acc <= '0;
            else if (since_acc != '0)
                since_acc <= since_acc + 8'd1;
        end
    end

    a_r3_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !blk_ready);

    a_r3_ready_window: assert property (@(posedge clk) disable iff (!rst_n)
        blk_ready == (since_acc == 8'd0 || since_acc == 8'(LAT)));

    a_r4_done_latency: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (since_acc == 8'(LAT)));

    a_r4_done_only_last: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> last_seen);

    a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r11_digest_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(digest) |-> (since_acc == 8'(LAT) || $past(init && blk_ready)));
endmodule

bind md5_core md5_core_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .init      (init),
    .blk_valid (blk_valid),
    .blk_ready (blk_ready),
    .blk_last  (blk_last),
    .digest    (digest),
    .done      (done)
);

// File: tb/md5_core_test.sv
module md5_core_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         init = 1'b0;
    logic         blk_valid = 1'b0;
    logic         blk_ready;
    logic [511:0] blk_data = '0;
    logic         blk_last = 1'b0;
    logic [127:0] digest;
    logic         done;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    logic [31:0] ma, mb, mc, md;

    localparam logic [127:0] IV_DIG = 128'h0123456789abcdeffedcba9876543210;

    always #10 clk = ~clk;

    md5_core uut (
        .clk(clk), .rst_n(rst_n), .init(init), .blk_valid(blk_valid),
        .blk_ready(blk_ready), .blk_data(blk_data), .blk_last(blk_last),
        .digest(digest), .done(done)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++; checks++;
            $display("FAIL watchdog: run did not finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input logic [127:0] act, input logic [127:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] bs(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    function automatic logic [31:0] tval(input int j);
        real r;
        r = $sin(real'(j + 1));
        if (r < 0.0) r = -r;
        return 32'(longint'($floor(r * 4294967296.0)));
    endfunction

    function automatic logic [127:0] exp_dig();
        return {bs(ma), bs(mb), bs(mc), bs(md)};
    endfunction

    task automatic model_iv();
        ma = 32'h67452301; mb = 32'hefcdab89; mc = 32'h98badcfe; md = 32'h10325476;
    endtask

    task automatic model_block(input logic [511:0] blk);
        logic [31:0] a, b, c, d, f, sum, rot, nb;
        a = ma; b = mb; c = mc; d = md;
        for (int j = 0; j < 64; j++) begin
            int r = j / 16;
            int i = j % 16;
            int k;
            int s;
            case (r)
                0: begin f = (b & c) | (~b & d); k = i; end
                1: begin f = (b & d) | (c & ~d); k = (5 * i + 1) % 16; end
                2: begin f = b ^ c ^ d;          k = (3 * i + 5) % 16; end
                default: begin f = c ^ (b | ~d); k = (7 * i) % 16; end
            endcase
            case (r * 4 + i % 4)
                0: s = 7;   1: s = 12;  2: s = 17;  3: s = 22;
                4: s = 5;   5: s = 9;   6: s = 14;  7: s = 20;
                8: s = 4;   9: s = 11;  10: s = 16; 11: s = 23;
                12: s = 6;  13: s = 10; 14: s = 15; default: s = 21;
            endcase
            sum = a + f + blk[32*k +: 32] + tval(j);
            rot = (sum << s) | (sum >> (32 - s));
            nb = b + rot;
            a = d; d = c; c = b; b = nb;
        end
        ma += a; mb += b; mc += c; md += d;
    endtask

    // Offer one block at a negedge while idle, then follow it to completion.
    // disturb: in busy cycle 10 drive init, blk_valid and other data for one cycle.
    task automatic run_block(input logic [511:0] blk, input bit last, input bit ini,
                             input bit disturb, input string tag);
        int n;
        bit done_seen;
        bit early;
        chk(128'(blk_ready), 128'(1), {tag, " R3 ready before offer"});
        blk_data = blk; blk_last = last; blk_valid = 1'b1; init = ini;
        @(negedge clk);
        blk_valid = 1'b0; init = 1'b0; blk_last = 1'b0; blk_data = ~blk;
        if (ini) model_iv();
        model_block(blk);
        n = 1; done_seen = 0; early = 0;
        while (!blk_ready && n < 200) begin
            if (done) early = 1;
            if (disturb && n == 10) begin
                init = 1'b1; blk_valid = 1'b1; blk_data = {16{32'h5a5aa5a5}}; blk_last = 1'b1;
            end
            @(negedge clk);
            if (disturb && n == 10) begin
                init = 1'b0; blk_valid = 1'b0; blk_last = 1'b0;
            end
            n++;
        end
        done_seen = done;
        chk(128'(n), 128'(66), {tag, " R3 busy length"});
        chk(128'(early), 128'(0), {tag, " R4 no early done"});
        chk(128'(done_seen), 128'(last), {tag, " R4 done iff last"});
        chk(digest, exp_dig(), {tag, " R5 digest"});
        @(negedge clk);
        chk(128'(done), 128'(0), {tag, " R4 done single pulse"});
        chk(digest, exp_dig(), {tag, " R11 digest holds"});
    endtask

    initial begin
        logic [511:0] blk;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(128'(blk_ready), 128'(1), "R1 ready after reset");
        chk(128'(done), 128'(0), "R1 done after reset");
        chk(digest, IV_DIG, "R1 digest after reset");

        // R6: byte order, empty message and "abc"
        model_iv();
        run_block(512'h80, 1'b1, 1'b1, 1'b0, "R6 empty");
        chk(digest, 128'hd41d8cd98f00b204e9800998ecf8427e, "R6 empty message digest");
        blk = '0; blk[31:0] = 32'h80636261; blk[32*14 +: 32] = 32'h18;
        run_block(blk, 1'b1, 1'b1, 1'b0, "R6 abc");
        chk(digest, 128'h900150983cd24fb0d6963f7d28e17f72, "R6 abc digest");

        // R2: init alone reloads the chaining value
        init = 1'b1;
        @(negedge clk);
        init = 1'b0;
        chk(digest, IV_DIG, "R2 init reload");
        model_iv();

        // R5: sweep of single-block messages with varied word patterns
        for (int t = 0; t < 40; t++) begin
            for (int w = 0; w < 16; w++)
                blk[32*w +: 32] = (t < 8) ? ((t[0] ? 32'hffffffff : 32'h0) ^ (32'h1 << (w + t)))
                                          : $urandom();
            run_block(blk, 1'b1, 1'b1, 1'b0, "R5 sweep");
        end

        // R7: three-block message chained without init
        for (int t = 0; t < 3; t++) begin
            for (int w = 0; w < 16; w++) blk[32*w +: 32] = $urandom();
            run_block(blk, t == 2, t == 0, 1'b0, "R7 chained");
        end

        // R8: init together with block acceptance, chain currently not IV
        for (int w = 0; w < 16; w++) blk[32*w +: 32] = $urandom();
        run_block(blk, 1'b1, 1'b1, 1'b0, "R8 init with block");

        // R9 and R10: init, valid and new data mid-compression are ignored
        for (int w = 0; w < 16; w++) blk[32*w +: 32] = $urandom();
        run_block(blk, 1'b0, 1'b0, 1'b1, "R9 R10 disturbed");
        for (int w = 0; w < 16; w++) blk[32*w +: 32] = $urandom();
        run_block(blk, 1'b1, 1'b0, 1'b1, "R9 R10 disturbed last");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule